// File: doc/BRIEF.md
# Bus Transfer Error Status Capture

This block sits beside a bus controller and records why a transfer-error acknowledge was raised on a bus access. It samples a set of error-cause inputs in every cycle: bus monitor timeout, a failed access to internal address space, a parity error on one or more byte lanes, a double-bit ECC error, a single-bit ECC error and a write-protect violation. It also samples the number of the memory bank being accessed. From these inputs it decides in the same cycle whether the transfer-error acknowledge output must pulse, and it keeps sticky flags that say which causes occurred.

Single-bit ECC errors are normally corrected without a visible error. Each corrected error advances a saturating counter. Once that counter sits at its maximum, every further single-bit error is treated as a real transfer error. A write-protect violation is only recorded and never raises the output by itself. At the first error after all flags are clear, the block takes a snapshot of the failing byte lanes, the bank and the internal slave identifier. That snapshot is held until software clears the flags, so the first fault is not overwritten by later ones.

Software uses a small register port with a two-bit address. Address 0 holds the status flags, which are cleared by writing ones. Address 1 is the read-only capture snapshot. Address 2 holds the error counter, and writing zero to it clears the counter.

Top module: `xerr_capture`

## Requirements
- R1: A bus monitor timeout input pulses `tea_o` in the same cycle and sets status bit 0.
- R2: An internal-space error pulses `tea_o`, sets status bit 1, and, when it is the first error, captures `int_slave_i` in capture-register bits [23:16].
- R3: A parity error on any byte lane pulses `tea_o`, sets status bit 2, and, when it is the first error, captures the lane mask in capture bits [7:0] and `bank_i` in capture bits [15:8].
- R4: A double-bit ECC error pulses `tea_o`, sets status bit 3, and, when it is the first error, captures `bank_i` in capture bits [15:8].
- R5: A single-bit ECC error while the counter (address 2, bits [CNT_W-1:0]) is below its maximum leaves `tea_o` low and sets no flag, and the counter increments by one.
- R6: A single-bit ECC error while the counter is at its maximum (2^CNT_W-1) pulses `tea_o` and sets status bit 4, and the counter stays at its maximum without wrapping.
- R7: A write-protect violation alone sets status bit 5 and leaves `tea_o` low.
- R8: After reset, the status, capture and counter registers all read zero, and `tea_o` is low.
- R9: Writing to address 0 clears each flag whose write-data bit is one and leaves the flags whose bit is zero unchanged. A flag set by an error in the same cycle stays set.
- R10: Writing zero to bits [CNT_W-1:0] at address 2 clears the counter. Writing a nonzero value there has no effect.
- R11: The capture register updates only on an error that arrives while all status flags are zero. Later errors leave it unchanged until the flags are cleared.
- R12: `tea_o` is high only in the cycle where a qualifying error input is present, and it is low in the following cycle when no error input is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bm_timeout_i | input | 1 | Bus monitor timeout |
| int_err_i | input | 1 | Error on an internal-space access |
| int_slave_i | input | SLV_W | Identifier of the failing internal slave |
| lane_par_err_i | input | LANES | Parity error, one bit per byte lane |
| ecc_dbl_i | input | 1 | Double-bit ECC error |
| ecc_sgl_i | input | 1 | Single-bit (corrected) ECC error |
| wr_prot_i | input | 1 | Write to a read-only region |
| bank_i | input | BANK_W | Memory bank of the current access |
| reg_addr_i | input | 2 | Register address (0 status, 1 capture, 2 counter) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| tea_o | output | 1 | Transfer-error acknowledge pulse |

## Verification
The hardest behaviour to reach is the escalation of single-bit errors. No flag and no output shows that the counter is approaching its limit. The stimulus therefore sends exactly 2^CNT_W-1 silent single-bit errors and checks `tea_o` low after each one. Only the next error may raise the output. The same scenario then writes a nonzero value and after that a zero value to the counter, to separate the ignored write from the clearing write. A second hard case is an error that coincides with a write-one-to-clear of the same flag. This is driven in a single cycle so that the new set must win.

// File: rtl/xerr_pkg.sv
package xerr_pkg;
    localparam int NFLAG  = 6;
    localparam int FLG_BM  = 0;
    localparam int FLG_INT = 1;
    localparam int FLG_PAR = 2;
    localparam int FLG_DBL = 3;
    localparam int FLG_SGL = 4;
    localparam int FLG_WP  = 5;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_STATUS  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CAPTURE = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT   = 2'd2;

    localparam int DATA_W       = 32;
    localparam int CAP_LANE_LSB = 0;
    localparam int CAP_BANK_LSB = 8;
    localparam int CAP_SLV_LSB  = 16;
endpackage

// File: rtl/xerr_classify.sv
module xerr_classify
    import xerr_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             bm_i,
    input  logic             int_i,
    input  logic [LANES-1:0] par_i,
    input  logic             dbl_i,
    input  logic             sgl_i,
    input  logic             wp_i,
    input  logic             sat_i,
    output logic [NFLAG-1:0] set_o,
    output logic             tea_o,
    output logic             sec_inc_o
);
    logic any_par;
    logic sgl_escalate;

    always_comb begin
        any_par      = |par_i;
        sgl_escalate = sgl_i & sat_i;

        set_o          = '0;
        set_o[FLG_BM]  = bm_i;
        set_o[FLG_INT] = int_i;
        set_o[FLG_PAR] = any_par;
        set_o[FLG_DBL] = dbl_i;
        set_o[FLG_SGL] = sgl_escalate;
        set_o[FLG_WP]  = wp_i;

        // write protect alone never escalates to a bus error
        tea_o     = bm_i | int_i | any_par | dbl_i | sgl_escalate;
        sec_inc_o = sgl_i & ~sat_i;
    end
endmodule

// File: rtl/xerr_sat_cnt.sv
module xerr_sat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && cnt_q != MAXV) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
    assign sat_o = (cnt_q == MAXV);
endmodule

// File: rtl/xerr_capture.sv
module xerr_capture
    import xerr_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int BANK_W = 4,
    parameter int SLV_W  = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bm_timeout_i,
    input  logic              int_err_i,
    input  logic [SLV_W-1:0]  int_slave_i,
    input  logic [LANES-1:0]  lane_par_err_i,
    input  logic              ecc_dbl_i,
    input  logic              ecc_sgl_i,
    input  logic              wr_prot_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              tea_o
);
    typedef struct packed {
        logic [NFLAG-1:0]  flags;
        logic [LANES-1:0]  lane;
        logic [BANK_W-1:0] bank;
        logic [SLV_W-1:0]  slv;
    } state_t;

    state_t st_d, st_q;

    logic [NFLAG-1:0] set_vec;
    logic             sec_inc;
    logic             cnt_sat;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_clr;
    logic [NFLAG-1:0] clr_mask;
    logic             unused_wdata;
    logic [NFLAG-1:0] flags_w;

    assign unused_wdata = ^reg_wdata_i;
    assign flags_w      = st_q.flags;

    xerr_classify #(.LANES(LANES)) u_classify (
        .bm_i      (bm_timeout_i),
        .int_i     (int_err_i),
        .par_i     (lane_par_err_i),
        .dbl_i     (ecc_dbl_i),
        .sgl_i     (ecc_sgl_i),
        .wp_i      (wr_prot_i),
        .sat_i     (cnt_sat),
        .set_o     (set_vec),
        .tea_o     (tea_o),
        .sec_inc_o (sec_inc)
    );

    xerr_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (sec_inc),
        .clr_i (cnt_clr),
        .cnt_o (cnt_val),
        .sat_o (cnt_sat)
    );

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (reg_wr_i && reg_addr_i == A_STATUS) begin
            clr_mask = reg_wdata_i[NFLAG-1:0];
        end
        cnt_clr = reg_wr_i && (reg_addr_i == A_COUNT) &&
                  (reg_wdata_i[CNT_W-1:0] == '0);

        // new error sets win over a simultaneous software clear
        st_d.flags = (st_q.flags & ~clr_mask) | set_vec;

        // snapshot only the first fault after a clean status
        if (st_q.flags == '0 && set_vec != '0) begin
            st_d.lane = lane_par_err_i;
            st_d.bank = bank_i;
            st_d.slv  = int_err_i ? int_slave_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_STATUS:  reg_rdata_o[NFLAG-1:0] = st_q.flags;
            A_CAPTURE: begin
                reg_rdata_o[CAP_LANE_LSB +: LANES]  = st_q.lane;
                reg_rdata_o[CAP_BANK_LSB +: BANK_W] = st_q.bank;
                reg_rdata_o[CAP_SLV_LSB  +: SLV_W]  = st_q.slv;
            end
            A_COUNT:   reg_rdata_o[CNT_W-1:0] = cnt_val;
            default:   reg_rdata_o = '0;
        endcase
    end
endmodule

module xerr_capture_chk
    import xerr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bm,
    input logic             inte,
    input logic [LANES-1:0] par,
    input logic             dbl,
    input logic             sgl,
    input logic             wp,
    input logic             tea,
    input logic [NFLAG-1:0] flags,
    input logic [CNT_W-1:0] cnt,
    input logic             wr,
    input logic [1:0]       addr
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    // covers R1, R2, R3 and R4: every hard error source raises the output
    p_hard_err_tea_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bm || inte || (par != '0) || dbl) |-> tea);

    p_wp_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wp && !bm && !inte && (par == '0) && !dbl && !sgl) |-> !tea);

    p_sgl_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sgl && cnt != MAXV && !bm && !inte && (par == '0) && !dbl) |-> !tea);

    p_cnt_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !(wr && addr == A_COUNT)) |=> cnt == MAXV);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == A_STATUS) |=> ((flags & $past(flags)) == $past(flags)));

    p_no_tea_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!bm && !inte && (par == '0) && !dbl && !sgl) |-> !tea);
endmodule

bind xerr_capture xerr_capture_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .bm    (bm_timeout_i),
    .inte  (int_err_i),
    .par   (lane_par_err_i),
    .dbl   (ecc_dbl_i),
    .sgl   (ecc_sgl_i),
    .wp    (wr_prot_i),
    .tea   (tea_o),
    .flags (flags_w),
    .cnt   (cnt_val),
    .wr    (reg_wr_i),
    .addr  (reg_addr_i)
);

// File: tb/xerr_capture_test.sv
module xerr_capture_test;
    localparam int CLK_P  = 10;
    localparam int LANES  = 8;
    localparam int BANK_W = 4;
    localparam int SLV_W  = 2;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bm = 1'b0, inte = 1'b0, dbl = 1'b0, sgl = 1'b0, wp = 1'b0;
    logic [SLV_W-1:0]  slv = '0;
    logic [LANES-1:0]  par = '0;
    logic [BANK_W-1:0] bank = '0;
    logic [1:0]        addr = '0;
    logic              wr = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              tea;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    xerr_capture #(.LANES(LANES), .BANK_W(BANK_W), .SLV_W(SLV_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .bm_timeout_i(bm), .int_err_i(inte),
        .int_slave_i(slv), .lane_par_err_i(par), .ecc_dbl_i(dbl), .ecc_sgl_i(sgl),
        .wr_prot_i(wp), .bank_i(bank), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tea_o(tea)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // one cycle of error inputs; tea sampled mid-cycle, state updated by the next edge
    task automatic pulse(input logic b, input logic i, input logic [SLV_W-1:0] s,
                         input logic [LANES-1:0] p, input logic d, input logic g,
                         input logic w, input logic [BANK_W-1:0] bk, output logic t);
        @(negedge clk);
        bm = b; inte = i; slv = s; par = p; dbl = d; sgl = g; wp = w; bank = bk;
        #1 t = tea;
        @(negedge clk);
        bm = 0; inte = 0; slv = '0; par = '0; dbl = 0; sgl = 0; wp = 0; bank = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wrt(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R8", "status after reset", d, 32'h0);
        rd(2'd1, d); check("R8", "capture after reset", d, 32'h0);
        rd(2'd2, d); check("R8", "counter after reset", d, 32'h0);
        check("R8", "tea after reset", {31'b0, tea}, 32'h0);
    endtask

    task automatic t_bus_monitor();
        logic t; logic [31:0] d;
        pulse(1, 0, 0, 0, 0, 0, 0, 4'd3, t);
        check("R1", "tea on timeout", {31'b0, t}, 32'h1);
        #1 check("R12", "tea low next cycle", {31'b0, tea}, 32'h0);
        rd(2'd0, d); check("R1", "status bit0", d, 32'h01);
        wrt(2'd0, 32'h3F);
        rd(2'd0, d); check("R9", "status after clear all", d, 32'h0);
    endtask

    task automatic t_parity_then_double();
        logic t; logic [31:0] d;
        pulse(0, 0, 0, 8'h04, 0, 0, 0, 4'd5, t);
        check("R3", "tea on parity", {31'b0, t}, 32'h1);
        rd(2'd0, d); check("R3", "status bit2", d, 32'h04);
        rd(2'd1, d); check("R3", "capture lane and bank", d, 32'h0000_0504);
        pulse(0, 0, 0, 0, 1, 0, 0, 4'd9, t);
        check("R4", "tea on double", {31'b0, t}, 32'h1);
        rd(2'd0, d); check("R4", "status bits 2 and 3", d, 32'h0C);
        rd(2'd1, d); check("R11", "capture held", d, 32'h0000_0504);
        wrt(2'd0, 32'h04);
        rd(2'd0, d); check("R9", "only bit2 cleared", d, 32'h08);
        wrt(2'd0, 32'h08);
        pulse(0, 0, 0, 0, 1, 0, 0, 4'd7, t);
        rd(2'd1, d); check("R4", "fresh capture of bank", d, 32'h0000_0700);
        wrt(2'd0, 32'h3F);
    endtask

    task automatic t_internal();
        logic t; logic [31:0] d;
        pulse(0, 1, 2'd2, 0, 0, 0, 0, 4'd1, t);
        check("R2", "tea on internal error", {31'b0, t}, 32'h1);
        rd(2'd0, d); check("R2", "status bit1", d, 32'h02);
        rd(2'd1, d); check("R2", "capture slave and bank", d, 32'h0002_0100);
        wrt(2'd0, 32'h3F);
    endtask

    task automatic t_write_protect();
        logic t; logic [31:0] d;
        pulse(0, 0, 0, 0, 0, 0, 1, 4'd6, t);
        check("R7", "no tea on write protect", {31'b0, t}, 32'h0);
        rd(2'd0, d); check("R7", "status bit5", d, 32'h20);
        wrt(2'd0, 32'h3F);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        bm = 1; addr = 2'd0; wdata = 32'h01; wr = 1;
        @(negedge clk);
        bm = 0; wr = 0; wdata = '0;
        rd(2'd0, d); check("R9", "set wins over clear", d, 32'h01);
        wrt(2'd0, 32'h3F);
        rd(2'd0, d); check("R9", "clear after set", d, 32'h0);
    endtask

    task automatic t_single_bit();
        logic t; logic [31:0] d; int silent_bad;
        silent_bad = 0;
        for (int k = 0; k < CMAX; k++) begin
            pulse(0, 0, 0, 0, 0, 1, 0, 4'd2, t);
            if (t !== 1'b0) silent_bad++;
        end
        check("R5", "silent corrected errors", silent_bad, 0);
        rd(2'd2, d); check("R5", "counter at max", d, CMAX);
        rd(2'd0, d); check("R5", "no flag while counting", d, 32'h0);
        pulse(0, 0, 0, 0, 0, 1, 0, 4'd2, t);
        check("R6", "tea after saturation", {31'b0, t}, 32'h1);
        rd(2'd0, d); check("R6", "status bit4", d, 32'h10);
        rd(2'd2, d); check("R6", "counter no wrap", d, CMAX);
        wrt(2'd2, 32'h5);
        rd(2'd2, d); check("R10", "nonzero write ignored", d, CMAX);
        wrt(2'd2, 32'h0);
        rd(2'd2, d); check("R10", "zero write clears", d, 32'h0);
        pulse(0, 0, 0, 0, 0, 1, 0, 4'd2, t);
        check("R5", "silent after clear", {31'b0, t}, 32'h0);
        rd(2'd2, d); check("R5", "counter one", d, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bus_monitor();
        t_parity_then_double();
        t_internal();
        t_write_protect();
        t_set_wins();
        t_single_bit();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule